// File: doc/BRIEF.md
# Prioritized Chip-Select Bank Decoder

This block turns an internal bus address into a chip select for one of eight external memory banks. Four are calibration banks and four are normal banks. Each bank has a base register and an option register. The base register holds a 17-bit base address and a valid flag. The option register holds a 17-bit compare mask and the bank's access attributes: the wait-state count, the burst enable and the external port size. The bus side presents a request strobe with an address. One clock later the block returns a one-hot chip-select vector, the winning bank's attributes and a hit or miss flag. The external bus sequencer then uses these to run the access, or to end it with an error on a miss.

When several banks match, they are ranked in two tiers. Any calibration bank beats every normal bank. Within each tier the lowest-numbered bank wins. The chip-select vector carries the calibration banks in bits 3..0 and the normal banks in bits 7..4, so the priority runs from bit 0 (highest) up to bit 7 (lowest). Software writes the registers through a plain address, data and write-enable port.

The response side is a three-state machine: `ST_IDLE` (no response presented), `ST_HIT` (a bank won) and `ST_MISS` (no valid bank matched). The transitions are the same from every state. With no request the machine goes to `ST_IDLE` (*go_idle*). A request with at least one matching bank goes to `ST_HIT` (*go_hit*). A request with no matching bank goes to `ST_MISS` (*go_miss*).

Top module: `csbank_decoder`

## Requirements
- R1: While reset is held, and after it is released, every bank's valid flag is clear. A request made before any base register is written with valid set gives a miss.
- R2: A bank's compare covers address bits 31..15. Where a mask bit is 1, the address bit must equal the base bit. Where a mask bit is 0, the address bit is ignored. Address bits 14..0 never take part.
- R3: A bank whose valid flag is 0 never matches, whatever its base and mask hold.
- R4: Among matching banks of the same tier, the lowest-numbered bank wins.
- R5: A match on any calibration bank (chip-select bits 3..0) overrides any match on a normal bank (bits 7..4).
- R6: On a hit, the wait-state, burst and port-size outputs equal the winning bank's option fields. Port size codes are 0 = 8-bit, 1 = 16-bit, 2 = 32-bit and 3 = reserved, and code 3 is passed through unchanged.
- R7: A request on one clock edge gives `rsp_valid` high for exactly the following cycle. With no request, `rsp_valid` is low. Back-to-back requests each get their own response.
- R8: On a miss, `rsp_miss` is 1, `rsp_hit` is 0, and the chip-select vector and all attribute outputs are zero.
- R9: Config writes use `cfg_addr[2:0]` as the bank index (0..3 calibration, 4..7 normal) and `cfg_addr[3]` to pick the register (0 = base, 1 = option). In the base word, bits 31..15 hold the base and bit 0 holds valid. In the option word, bits 31..15 hold the mask, bits 7..4 the wait states, bit 2 burst enable and bits 1..0 the port size. A write is used by requests on later edges.
- R10: The chip-select vector never has more than one bit set. On a hit it has exactly one bit set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_we | input | 1 | Config write strobe |
| cfg_addr | input | 4 | Bank index [2:0], register select [3] |
| cfg_wdata | input | 32 | Config write data |
| req_valid | input | 1 | Access request strobe |
| req_addr | input | 32 | Access address |
| rsp_valid | output | 1 | Response presented this cycle |
| cs_onehot | output | 8 | Winning chip select, cal 3..0, normal 7..4 |
| rsp_hit | output | 1 | A bank matched |
| rsp_miss | output | 1 | No valid bank matched |
| rsp_wait | output | 4 | Winner's wait-state count |
| rsp_burst | output | 1 | Winner's burst enable |
| rsp_psize | output | 2 | Winner's port size code |

## Verification
The assertions assume that `req_valid` and `cfg_we` are never X after reset. They also assume that the response cycle is the one right after the request edge, with no stall input that could hold it. The bench drives every input at the falling clock edge, so nothing changes near the active edge. It never writes a register in the same cycle as a request whose result depends on that write. The bank layout it programs deliberately overlaps regions within each tier and across the two tiers. It also places an invalid bank over a valid one, so the priority checks have real contention to resolve.

// File: rtl/csdec_pkg.sv
package csdec_pkg;
    localparam int CMP_W  = 17;
    localparam int WAIT_W = 4;

    typedef enum logic [1:0] {
        PS_8    = 2'd0,
        PS_16   = 2'd1,
        PS_32   = 2'd2,
        PS_RSVD = 2'd3
    } psize_e;

    typedef struct packed {
        logic [CMP_W-1:0]  base;
        logic              valid;
        logic [CMP_W-1:0]  mask;
        logic [WAIT_W-1:0] waits;
        logic              burst;
        psize_e            psize;
    } bank_cfg_t;

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_HIT  = 2'd1,
        ST_MISS = 2'd2
    } rsp_state_e;
endpackage

// File: rtl/csdec_bank_regs.sv
module csdec_bank_regs
    import csdec_pkg::*;
#(
    parameter int NBANK  = 8,
    parameter int ADDR_W = 32,
    localparam int IDX_W = $clog2(NBANK),
    localparam int CFG_AW = IDX_W + 1
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    cfg_we,
    input  logic [CFG_AW-1:0]       cfg_addr,
    input  logic [ADDR_W-1:0]       cfg_wdata,
    output bank_cfg_t [NBANK-1:0]   cfg_o
);
    localparam int FLD_LSB = ADDR_W - CMP_W;

    logic [NBANK-1:0] valid_vec;

    for (genvar g = 0; g < NBANK; g++) begin : g_bank
        logic sel;
        assign sel = cfg_we && (int'(cfg_addr[IDX_W-1:0]) == g);

        always_ff @(posedge clk) begin
            if (!rst_n) begin
                cfg_o[g] <= '0;
            end else if (sel && !cfg_addr[IDX_W]) begin
                cfg_o[g].base  <= cfg_wdata[FLD_LSB +: CMP_W];
                cfg_o[g].valid <= cfg_wdata[0];
            end else if (sel && cfg_addr[IDX_W]) begin
                cfg_o[g].mask  <= cfg_wdata[FLD_LSB +: CMP_W];
                cfg_o[g].waits <= cfg_wdata[4 +: WAIT_W];
                cfg_o[g].burst <= cfg_wdata[2];
                cfg_o[g].psize <= psize_e'(cfg_wdata[1:0]);
            end
        end

        assign valid_vec[g] = cfg_o[g].valid;
    end

    AST_RESET_INVALIDATES: assert property (@(posedge clk)
        !rst_n |=> (valid_vec == '0)); // R1
endmodule

// File: rtl/csdec_match.sv
module csdec_match
    import csdec_pkg::*;
#(
    parameter int NBANK  = 8,
    parameter int ADDR_W = 32
) (
    input  logic [ADDR_W-1:0]     addr,
    input  bank_cfg_t [NBANK-1:0] cfg_i,
    output logic [NBANK-1:0]      hit
);
    logic [CMP_W-1:0] upper;
    assign upper = addr[ADDR_W-1 -: CMP_W];

    for (genvar g = 0; g < NBANK; g++) begin : g_cmp
        logic [CMP_W-1:0] diff;
        assign diff   = (upper ^ cfg_i[g].base) & cfg_i[g].mask;
        assign hit[g] = cfg_i[g].valid && (diff == '0);
    end
endmodule

// File: rtl/csdec_prio.sv
module csdec_prio #(
    parameter int NBANK   = 8,
    parameter int NUM_CAL = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [NBANK-1:0] hit,
    output logic [NBANK-1:0] grant
);
    always_comb begin
        grant = '0;
        for (int i = NBANK - 1; i >= 0; i--) begin
            if (hit[i]) grant = NBANK'(1) << i;
        end
    end

    AST_CAL_TIER_WINS: assert property (@(posedge clk) disable iff (!rst_n)
        (|hit[NUM_CAL-1:0]) |-> (grant[NBANK-1:NUM_CAL] == '0)); // R5
    AST_GRANT_LOWEST: assert property (@(posedge clk) disable iff (!rst_n)
        (grant != '0) |-> ((hit & (grant - NBANK'(1))) == '0)); // R4
    AST_GRANT_IF_ANY: assert property (@(posedge clk) disable iff (!rst_n)
        (hit != '0) |-> ($countones(grant) == 1)); // R10
endmodule

// File: rtl/csbank_decoder.sv
module csbank_decoder
    import csdec_pkg::*;
#(
    parameter int NUM_CAL = 4,
    parameter int NUM_NRM = 4,
    parameter int ADDR_W  = 32,
    localparam int NBANK  = NUM_CAL + NUM_NRM,
    localparam int CFG_AW = $clog2(NBANK) + 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cfg_we,
    input  logic [CFG_AW-1:0] cfg_addr,
    input  logic [ADDR_W-1:0] cfg_wdata,
    input  logic              req_valid,
    input  logic [ADDR_W-1:0] req_addr,
    output logic              rsp_valid,
    output logic [NBANK-1:0]  cs_onehot,
    output logic              rsp_hit,
    output logic              rsp_miss,
    output logic [WAIT_W-1:0] rsp_wait,
    output logic              rsp_burst,
    output logic [1:0]        rsp_psize
);
    bank_cfg_t [NBANK-1:0] cfg;
    logic [NBANK-1:0]      hit, grant;

    csdec_bank_regs #(.NBANK(NBANK), .ADDR_W(ADDR_W)) u_regs (
        .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_addr(cfg_addr),
        .cfg_wdata(cfg_wdata), .cfg_o(cfg)
    );

    csdec_match #(.NBANK(NBANK), .ADDR_W(ADDR_W)) u_match (
        .addr(req_addr), .cfg_i(cfg), .hit(hit)
    );

    csdec_prio #(.NBANK(NBANK), .NUM_CAL(NUM_CAL)) u_prio (
        .clk(clk), .rst_n(rst_n), .hit(hit), .grant(grant)
    );

    // attribute select: OR of the granted bank's fields
    logic [WAIT_W-1:0] sel_wait;
    logic              sel_burst;
    logic [1:0]        sel_psize;

    always_comb begin
        sel_wait  = '0;
        sel_burst = 1'b0;
        sel_psize = '0;
        for (int i = 0; i < NBANK; i++) begin
            if (grant[i]) begin
                sel_wait  = sel_wait  | cfg[i].waits;
                sel_burst = sel_burst | cfg[i].burst;
                sel_psize = sel_psize | 2'(cfg[i].psize);
            end
        end
    end

    // response state machine
    rsp_state_e        st_q, st_d;
    logic [NBANK-1:0]  cs_q;
    logic [WAIT_W-1:0] wait_q;
    logic              burst_q;
    logic [1:0]        psize_q;

    always_comb begin
        if (!req_valid)      st_d = ST_IDLE;  // go_idle
        else if (|grant)     st_d = ST_HIT;   // go_hit
        else                 st_d = ST_MISS;  // go_miss
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q    <= ST_IDLE;
            cs_q    <= '0;
            wait_q  <= '0;
            burst_q <= 1'b0;
            psize_q <= '0;
        end else begin
            st_q <= st_d;
            if (req_valid) begin
                cs_q    <= grant;
                wait_q  <= sel_wait;
                burst_q <= sel_burst;
                psize_q <= sel_psize;
            end
        end
    end

    always_comb begin
        rsp_valid = 1'b0;
        rsp_hit   = 1'b0;
        rsp_miss  = 1'b0;
        cs_onehot = '0;
        rsp_wait  = '0;
        rsp_burst = 1'b0;
        rsp_psize = '0;
        unique case (st_q)
            ST_IDLE: ;
            ST_HIT: begin
                rsp_valid = 1'b1;
                rsp_hit   = 1'b1;
                cs_onehot = cs_q;
                rsp_wait  = wait_q;
                rsp_burst = burst_q;
                rsp_psize = psize_q;
            end
            ST_MISS: begin
                rsp_valid = 1'b1;
                rsp_miss  = 1'b1;
            end
            default: ;
        endcase
    end

    AST_CS_ONEHOT: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(cs_onehot)); // R10
    AST_HIT_ONE_CS: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_hit |-> ($countones(cs_onehot) == 1)); // R10
    AST_MISS_DARK: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_miss |-> (cs_onehot == '0 && rsp_wait == '0 && !rsp_burst
                      && rsp_psize == '0 && !rsp_hit)); // R8
    AST_REQ_RESPONDS: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid |=> rsp_valid); // R7
    AST_NO_SPURIOUS: assert property (@(posedge clk) disable iff (!rst_n)
        !req_valid |=> !rsp_valid); // R7
    AST_VALID_IS_HIT_OR_MISS: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid |-> (rsp_hit ^ rsp_miss)); // R8
endmodule

// File: tb/tb_csbank_decoder.sv
`timescale 1ns/1ps
module tb_csbank_decoder;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cfg_we = 1'b0;
    logic [3:0]  cfg_addr = '0;
    logic [31:0] cfg_wdata = '0;
    logic        req_valid = 1'b0;
    logic [31:0] req_addr = '0;
    logic        rsp_valid, rsp_hit, rsp_miss, rsp_burst;
    logic [7:0]  cs_onehot;
    logic [3:0]  rsp_wait;
    logic [1:0]  rsp_psize;

    int checks = 0;
    int fails  = 0;

    always #2 clk = ~clk;

    csbank_decoder dut (
        .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_addr(cfg_addr),
        .cfg_wdata(cfg_wdata), .req_valid(req_valid), .req_addr(req_addr),
        .rsp_valid(rsp_valid), .cs_onehot(cs_onehot), .rsp_hit(rsp_hit),
        .rsp_miss(rsp_miss), .rsp_wait(rsp_wait), .rsp_burst(rsp_burst),
        .rsp_psize(rsp_psize)
    );

    typedef struct packed {
        logic [31:0] addr;
        logic [7:0]  cs;
        logic [3:0]  w;
        logic        b;
        logic [1:0]  p;
        logic        miss;
    } vec_t;

    localparam int NV = 11;
    localparam vec_t VECS [NV] = '{
        '{32'h2000_1234, 8'h01, 4'd1,  1'b0, 2'd2, 1'b0}, // cal0 over cal1 and n0
        '{32'h2000_7FFF, 8'h01, 4'd1,  1'b0, 2'd2, 1'b0}, // low bits ignored
        '{32'h2000_8000, 8'h02, 4'd2,  1'b1, 2'd1, 1'b0}, // cal1 only in cal tier
        '{32'h2010_0000, 8'h10, 4'd4,  1'b1, 2'd2, 1'b0}, // normal n0
        '{32'h6ABC_0000, 8'h08, 4'd3,  1'b0, 2'd0, 1'b0}, // cal3
        '{32'h4000_0010, 8'h20, 4'd5,  1'b0, 2'd1, 1'b0}, // invalid cal2 skipped, n1 over n2
        '{32'h4100_0000, 8'h40, 4'd6,  1'b1, 2'd0, 1'b0}, // n2
        '{32'h9000_0000, 8'h80, 4'd15, 1'b1, 2'd2, 1'b0}, // n3
        '{32'hF000_0000, 8'h80, 4'd15, 1'b1, 2'd2, 1'b0}, // n3 masked bits
        '{32'h0000_0000, 8'h00, 4'd0,  1'b0, 2'd0, 1'b1}, // miss
        '{32'h1000_0000, 8'h00, 4'd0,  1'b0, 2'd0, 1'b1}  // miss
    };

    task automatic check(input string tag, input logic [31:0] got, input logic [31:0] exp);
        checks++;
        if (got !== exp) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", tag, got, exp);
        end
    endtask

    task automatic cfg_write(input logic [3:0] a, input logic [31:0] d);
        @(negedge clk);
        cfg_we = 1'b1; cfg_addr = a; cfg_wdata = d;
        @(negedge clk);
        cfg_we = 1'b0;
    endtask

    function automatic logic [31:0] opt_word(input logic [31:0] mask, input logic [3:0] w,
                                             input logic b, input logic [1:0] p);
        return (mask & 32'hFFFF_8000) | (32'(w) << 4) | (32'(b) << 2) | 32'(p);
    endfunction

    task automatic request(input logic [31:0] a);
        @(negedge clk);
        req_valid = 1'b1; req_addr = a;
        @(negedge clk);
        req_valid = 1'b0;
    endtask

    task automatic expect_rsp(input string tag, input logic [7:0] cs, input logic [3:0] w,
                              input logic b, input logic [1:0] p, input logic miss);
        check({tag, " rsp_valid R7"}, 32'(rsp_valid), 32'd1);
        check({tag, " cs R4 R5"}, 32'(cs_onehot), 32'(cs));
        check({tag, " wait R6"}, 32'(rsp_wait), 32'(w));
        check({tag, " burst R6"}, 32'(rsp_burst), 32'(b));
        check({tag, " psize R6"}, 32'(rsp_psize), 32'(p));
        check({tag, " miss R8"}, 32'(rsp_miss), 32'(miss));
        check({tag, " hit R8"}, 32'(rsp_hit), 32'(!miss));
        check({tag, " onehot R10"}, 32'($countones(cs_onehot) <= 1), 32'd1);
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        fails++;
        $display("FAIL R7 watchdog actual=timeout expected=finished");
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        check("R1 reset rsp_valid", 32'(rsp_valid), 32'd0);
        check("R1 reset cs", 32'(cs_onehot), 32'd0);
        rst_n = 1'b1;

        // R1: nothing configured yet, so even a catch-all mask cannot match
        request(32'h2000_1234);
        expect_rsp("R1 unconfigured", 8'h00, 4'd0, 1'b0, 2'd0, 1'b1);

        // R9: program banks (option first, then base with valid)
        cfg_write(4'h8, opt_word(32'hFFFF_8000, 4'd1, 1'b0, 2'd2));  // cal0
        cfg_write(4'h0, 32'h2000_0001);
        cfg_write(4'h9, opt_word(32'hFFF0_0000, 4'd2, 1'b1, 2'd1));  // cal1
        cfg_write(4'h1, 32'h2000_0001);
        cfg_write(4'hA, opt_word(32'hFFFF_8000, 4'd9, 1'b1, 2'd3));  // cal2, invalid
        cfg_write(4'h2, 32'h4000_0000);
        cfg_write(4'hB, opt_word(32'hF000_0000, 4'd3, 1'b0, 2'd0));  // cal3
        cfg_write(4'h3, 32'h6000_0001);
        cfg_write(4'hC, opt_word(32'hF000_0000, 4'd4, 1'b1, 2'd2));  // n0
        cfg_write(4'h4, 32'h2000_0001);
        cfg_write(4'hD, opt_word(32'hFFFF_8000, 4'd5, 1'b0, 2'd1));  // n1
        cfg_write(4'h5, 32'h4000_0001);
        cfg_write(4'hE, opt_word(32'hF000_0000, 4'd6, 1'b1, 2'd0));  // n2
        cfg_write(4'h6, 32'h4000_0001);
        cfg_write(4'hF, opt_word(32'h8000_0000, 4'd15, 1'b1, 2'd2)); // n3
        cfg_write(4'h7, 32'h8000_0001);

        // table walk: R2 R3 R4 R5 R6 R8 R9 R10
        for (int i = 0; i < NV; i++) begin
            request(VECS[i].addr);
            expect_rsp($sformatf("vec%0d R2 R9", i), VECS[i].cs, VECS[i].w,
                       VECS[i].b, VECS[i].p, VECS[i].miss);
        end

        // R7: idle cycle shows no response
        @(negedge clk);
        check("R7 idle rsp_valid", 32'(rsp_valid), 32'd0);
        check("R7 idle cs", 32'(cs_onehot), 32'd0);

        // R7: back-to-back requests
        @(negedge clk);
        req_valid = 1'b1; req_addr = 32'h6000_0000;
        @(negedge clk);
        req_addr = 32'h0000_0000;
        expect_rsp("R7 b2b first", 8'h08, 4'd3, 1'b0, 2'd0, 1'b0);
        @(negedge clk);
        req_valid = 1'b0;
        expect_rsp("R7 b2b second", 8'h00, 4'd0, 1'b0, 2'd0, 1'b1);

        // R3: clear cal0 valid, cal1 now wins the overlap
        cfg_write(4'h0, 32'h2000_0000);
        request(32'h2000_1234);
        expect_rsp("R3 cal0 invalid", 8'h02, 4'd2, 1'b1, 2'd1, 1'b0);

        // R5: with cal0 and cal1 gone, the normal bank n0 takes it
        cfg_write(4'h1, 32'h2000_0000);
        request(32'h2000_1234);
        expect_rsp("R5 no cal hit", 8'h10, 4'd4, 1'b1, 2'd2, 1'b0);

        // R6: reserved port-size code passes through; option write keeps valid (R9)
        cfg_write(4'hB, opt_word(32'hF000_0000, 4'd7, 1'b1, 2'd3));
        request(32'h6123_4567);
        expect_rsp("R6 reserved psize", 8'h08, 4'd7, 1'b1, 2'd3, 1'b0);

        // R2: mask bit 0 ignores the address bit, mask bit 1 enforces it
        cfg_write(4'hD, opt_word(32'hFFFF_0000, 4'd5, 1'b0, 2'd1));
        request(32'h4000_8000);
        expect_rsp("R2 mask relaxed", 8'h20, 4'd5, 1'b0, 2'd1, 1'b0);

        // R1: reset again clears all valid flags
        @(negedge clk);
        rst_n = 1'b0;
        @(negedge clk);
        rst_n = 1'b1;
        request(32'h9000_0000);
        expect_rsp("R1 after reset", 8'h00, 4'd0, 1'b0, 2'd0, 1'b1);

        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end
endmodule